// File: doc/BRIEF.md
# Supply and Fault Protection Supervisor

This block decides, cycle by cycle, whether a flyback power stage may switch. It receives comparator flags that report where the controller supply sits against its thresholds, together with flags for an open feedback loop, supply over-voltage, two temperature-pin levels, low line voltage and a shorted current-sense resistor. From these flags it sequences startup, undervoltage shutdown, protective restart and latched shutdown. It also commands the high-voltage startup charger and a reduced discharge sink.

Each fault flag passes through its own debounce counter on the system clock. Over-voltage and the two temperature faults latch the block off until the supply has collapsed. The open-loop and sense-short faults shut switching down and then start again through a slow restart. In that restart the sink drains the supply from the 11 V level to the 7 V level before the charger runs again. After such a fault the running turn-off level rises from 6.5 V to 11 V. A low line stops switching, and switching starts again only when the line is back and the supply has enough headroom.

Top module: `supply_fault_supervisor`

## Requirements
- R1: After reset the charger is on, switching and the sink are off, and the fault code is 0.
- R2: Switching starts one clock after the supply-at-17 V flag, the line-above-brown-in flag and the supply-headroom flag are all high at the same time. If any one of them is low, switching does not start.
- R3: When no fault has occurred, switching stops one clock after the supply-below-6.5 V flag. The charger stays off until the supply-below-4.7 V flag is seen.
- R4: A fault acts only after its condition has been high for the number of consecutive clocks set by its own parameter. It then acts one clock later. If the condition drops before that count is reached, the count starts again from zero.
- R5: Open-loop (code 4) and sense-short (code 5) faults stop switching and report their code. The sink turns on when the supply falls below 11 V. Once the supply falls below 7 V the sink turns off and the charger turns on, and startup follows R2.
- R6: Once an auto-recovery fault has occurred, switching stops when the supply falls below 11 V, and the sink turns on instead of the normal undervoltage wait.
- R7: Over-voltage (code 1), critical temperature (code 2) and warm temperature (code 3) latch switching off, and the 17 V flag is ignored. While latched, the charger turns on below 7 V and turns off only when the supply is at or above 11 V.
- R8: A latched fault code holds until the supply-below-4 V flag is seen. One clock later the code becomes 0 and the block is back in its charging state.
- R9: A low line held for its debounce time stops switching with code 6. Switching resumes one clock after the line-above-brown-in flag and the headroom flag are both high, and stays off while the headroom flag is low.
- R10: When several faults qualify in the same clock, the reported code is the lowest-numbered one. A latched fault always overrides an auto-recovery fault.
- R11: Switching and the charger are never on together. The sink is on only while both of them are off.
- R12: A latched fault also acts while the block is charging or waiting, not only while switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vdd_ge_on | input | 1 | Supply at or above 17 V |
| vdd_lt_uvlo | input | 1 | Supply below 6.5 V |
| vdd_lt_restart | input | 1 | Supply below 4.7 V |
| vdd_lt_prot_off | input | 1 | Supply below 11 V |
| vdd_lt_prot_rearm | input | 1 | Supply below 7 V |
| vdd_lt_unlatch | input | 1 | Supply below 4 V |
| vdd_ge_brownin | input | 1 | Supply at least 3 V above the 6.5 V level |
| vdd_gt_ovp | input | 1 | Supply above 24.5 V |
| fb_gt_olp | input | 1 | Feedback above the open-loop level |
| temp_lt_warn | input | 1 | Temperature pin below the first level |
| temp_lt_crit | input | 1 | Temperature pin below the second level |
| line_lt_brownout | input | 1 | Sensed line below the brownout level |
| line_ge_brownin | input | 1 | Sensed line above the brown-in level |
| sense_low | input | 1 | Current-sense sample below the short threshold |
| sw_en | output | 1 | Switching allowed |
| chg_en | output | 1 | High-voltage startup charger on |
| sink_en | output | 1 | Reduced discharge sink on |
| fault_code | output | 3 | Cause of the present shutdown, 0 when none |

## Verification
The assertions check on every cycle the rules that a single clock can show. Switching, the charger and the sink must stay mutually exclusive. A latched code must hold until the 4 V flag and then clear. Switching may only start when the line and headroom flags were both high, and the charger and sink may only turn on just after their supply thresholds. Only the bench's scenarios can show the multi-step behaviours: the exact debounce count and its restart, the raised turn-off level after a fault, hysteresis of the charger while latched, brown-in gating and the choice between faults that qualify together.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int FAULT_NUM = 6;

    // Fault slot order doubles as priority: lower slot wins, code = slot + 1.
    localparam int SLOT_OVP   = 0;
    localparam int SLOT_TCRIT = 1;
    localparam int SLOT_TWARN = 2;
    localparam int SLOT_OLP   = 3;
    localparam int SLOT_SSCP  = 4;
    localparam int SLOT_BROWN = 5;

    localparam logic [FAULT_NUM-1:0] LATCH_MASK = 6'b000111;
    localparam logic [FAULT_NUM-1:0] AUTO_MASK  = 6'b011000;
    localparam logic [FAULT_NUM-1:0] BROWN_MASK = 6'b100000;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_OVP   = 3'd1,
        FC_TCRIT = 3'd2,
        FC_TWARN = 3'd3,
        FC_OLP   = 3'd4,
        FC_SSCP  = 3'd5,
        FC_BROWN = 3'd6
    } fault_code_e;

    typedef enum logic [2:0] {
        ST_CHARGE,
        ST_RUN,
        ST_UV_WAIT,
        ST_PROT_HOLD,
        ST_SINK,
        ST_BROWN,
        ST_LATCH
    } sup_state_e;

    typedef struct packed {
        logic ge_on;
        logic lt_uvlo;
        logic lt_restart;
        logic lt_prot_off;
        logic lt_prot_rearm;
        logic lt_unlatch;
        logic ge_brownin;
    } vdd_flags_t;

    typedef struct packed {
        sup_state_e  st;
        logic        prot;
        logic [2:0]  code;
        logic        lchg;
    } seq_regs_t;

endpackage

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_C = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } deb_regs_t;

    deb_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!cond_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LEN_C) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign qual_o = (r_q.cnt == LEN_C);
endmodule

// File: rtl/sup_fault_arb.sv
module sup_fault_arb
    import sup_pkg::*;
(
    input  logic [FAULT_NUM-1:0] qual_i,
    output logic [2:0]           code_o,
    output logic                 latch_hit_o,
    output logic                 auto_hit_o,
    output logic                 brown_hit_o
);
    always_comb begin
        code_o = 3'(FC_NONE);
        for (int i = FAULT_NUM - 1; i >= 0; i--) begin
            if (qual_i[i]) begin
                code_o = 3'(i + 1);
            end
        end
    end

    // Priority: any latched fault masks the lower classes entirely.
    assign latch_hit_o = |(qual_i & LATCH_MASK);
    assign auto_hit_o  = !latch_hit_o && |(qual_i & AUTO_MASK);
    assign brown_hit_o = !latch_hit_o && !auto_hit_o && |(qual_i & BROWN_MASK);
endmodule

// File: rtl/sup_seq.sv
module sup_seq
    import sup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  vdd_flags_t  vdd_i,
    input  logic        line_ok_i,
    input  logic        latch_hit_i,
    input  logic        auto_hit_i,
    input  logic        brown_hit_i,
    input  logic [2:0]  win_code_i,
    output logic        sw_en_o,
    output logic        chg_en_o,
    output logic        sink_en_o,
    output logic [2:0]  code_o
);
    seq_regs_t s_d, s_q;
    logic      brownin_ok;
    logic      run_drop;

    assign brownin_ok = line_ok_i && vdd_i.ge_brownin;
    // Turn-off level depends on whether a protective restart has happened.
    assign run_drop   = s_q.prot ? vdd_i.lt_prot_off : vdd_i.lt_uvlo;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_CHARGE: begin
                if (vdd_i.ge_on && brownin_ok) begin
                    s_d.st   = ST_RUN;
                    s_d.code = 3'(FC_NONE);
                end
            end
            ST_RUN: begin
                if (auto_hit_i) begin
                    s_d.st   = ST_PROT_HOLD;
                    s_d.prot = 1'b1;
                    s_d.code = win_code_i;
                end else if (brown_hit_i) begin
                    s_d.st   = ST_BROWN;
                    s_d.code = 3'(FC_BROWN);
                end else if (run_drop) begin
                    s_d.st = s_q.prot ? ST_SINK : ST_UV_WAIT;
                end
            end
            ST_UV_WAIT: begin
                if (vdd_i.lt_restart) begin
                    s_d.st = ST_CHARGE;
                end
            end
            ST_PROT_HOLD: begin
                if (vdd_i.lt_prot_off) begin
                    s_d.st = ST_SINK;
                end
            end
            ST_SINK: begin
                if (vdd_i.lt_prot_rearm) begin
                    s_d.st = ST_CHARGE;
                end
            end
            ST_BROWN: begin
                if (brownin_ok) begin
                    s_d.st   = ST_RUN;
                    s_d.code = 3'(FC_NONE);
                end else if (run_drop) begin
                    s_d.st = s_q.prot ? ST_SINK : ST_UV_WAIT;
                end
            end
            ST_LATCH: begin
                if (vdd_i.lt_unlatch) begin
                    s_d.st   = ST_CHARGE;
                    s_d.prot = 1'b0;
                    s_d.code = 3'(FC_NONE);
                    s_d.lchg = 1'b0;
                end else if (vdd_i.lt_prot_rearm) begin
                    s_d.lchg = 1'b1;
                end else if (!vdd_i.lt_prot_off) begin
                    s_d.lchg = 1'b0;
                end
            end
            default: begin
                s_d.st = ST_CHARGE;
            end
        endcase

        if (latch_hit_i && (s_q.st != ST_LATCH)) begin
            s_d.st   = ST_LATCH;
            s_d.code = win_code_i;
            s_d.lchg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_CHARGE, prot: 1'b0, code: 3'(FC_NONE), lchg: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sw_en_o   = (s_q.st == ST_RUN);
    assign chg_en_o  = (s_q.st == ST_CHARGE) || ((s_q.st == ST_LATCH) && s_q.lchg);
    assign sink_en_o = (s_q.st == ST_SINK);
    assign code_o    = s_q.code;
endmodule

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned OVP_CYC   = 8,
    parameter int unsigned TCRIT_CYC = 6,
    parameter int unsigned TWARN_CYC = 40,
    parameter int unsigned OLP_CYC   = 30,
    parameter int unsigned SSCP_CYC  = 11,
    parameter int unsigned BROWN_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_ge_on,
    input  logic       vdd_lt_uvlo,
    input  logic       vdd_lt_restart,
    input  logic       vdd_lt_prot_off,
    input  logic       vdd_lt_prot_rearm,
    input  logic       vdd_lt_unlatch,
    input  logic       vdd_ge_brownin,
    input  logic       vdd_gt_ovp,
    input  logic       fb_gt_olp,
    input  logic       temp_lt_warn,
    input  logic       temp_lt_crit,
    input  logic       line_lt_brownout,
    input  logic       line_ge_brownin,
    input  logic       sense_low,
    output logic       sw_en,
    output logic       chg_en,
    output logic       sink_en,
    output logic [2:0] fault_code
);
    localparam int unsigned DEB_LEN [FAULT_NUM] =
        '{OVP_CYC, TCRIT_CYC, TWARN_CYC, OLP_CYC, SSCP_CYC, BROWN_CYC};

    logic [FAULT_NUM-1:0] raw_cond;
    logic [FAULT_NUM-1:0] qual;
    logic [2:0]           win_code;
    logic                 latch_hit, auto_hit, brown_hit;
    vdd_flags_t           vdd;

    always_comb begin
        raw_cond             = '0;
        raw_cond[SLOT_OVP]   = vdd_gt_ovp;
        raw_cond[SLOT_TCRIT] = temp_lt_crit;
        raw_cond[SLOT_TWARN] = temp_lt_warn;
        raw_cond[SLOT_OLP]   = fb_gt_olp;
        raw_cond[SLOT_SSCP]  = sense_low;
        raw_cond[SLOT_BROWN] = line_lt_brownout;
    end

    assign vdd = '{ge_on: vdd_ge_on, lt_uvlo: vdd_lt_uvlo, lt_restart: vdd_lt_restart,
                   lt_prot_off: vdd_lt_prot_off, lt_prot_rearm: vdd_lt_prot_rearm,
                   lt_unlatch: vdd_lt_unlatch, ge_brownin: vdd_ge_brownin};

    for (genvar g = 0; g < FAULT_NUM; g++) begin : g_deb
        sup_debounce #(.LEN(DEB_LEN[g])) deb_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (raw_cond[g]),
            .qual_o (qual[g])
        );
    end

    sup_fault_arb arb_i (
        .qual_i      (qual),
        .code_o      (win_code),
        .latch_hit_o (latch_hit),
        .auto_hit_o  (auto_hit),
        .brown_hit_o (brown_hit)
    );

    sup_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vdd_i       (vdd),
        .line_ok_i   (line_ge_brownin),
        .latch_hit_i (latch_hit),
        .auto_hit_i  (auto_hit),
        .brown_hit_i (brown_hit),
        .win_code_i  (win_code),
        .sw_en_o     (sw_en),
        .chg_en_o    (chg_en),
        .sink_en_o   (sink_en),
        .code_o      (fault_code)
    );
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_lt_restart,
    input logic       vdd_lt_prot_off,
    input logic       vdd_lt_prot_rearm,
    input logic       vdd_lt_unlatch,
    input logic       vdd_ge_brownin,
    input logic       line_ge_brownin,
    input logic       sw_en,
    input logic       chg_en,
    input logic       sink_en,
    input logic [2:0] fault_code
);
    logic code_latched;
    assign code_latched = (fault_code == 3'd1) || (fault_code == 3'd2) || (fault_code == 3'd3);

    assert_excl_sw_chg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && chg_en));

    assert_sink_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sink_en |-> (!sw_en && !chg_en));

    assert_latch_no_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_latched |-> !sw_en);

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_latched && !vdd_lt_unlatch) |=> (fault_code == $past(fault_code)));

    assert_code_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_latched && vdd_lt_unlatch) |=> (fault_code == 3'd0));

    assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> ($past(vdd_ge_brownin) && $past(line_ge_brownin)));

    assert_sink_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sink_en) |-> $past(vdd_lt_prot_off));

    assert_chg_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_en) |-> $past(vdd_lt_restart || vdd_lt_prot_rearm || vdd_lt_unlatch));
endmodule

bind supply_fault_supervisor sup_checker chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .vdd_lt_restart    (vdd_lt_restart),
    .vdd_lt_prot_off   (vdd_lt_prot_off),
    .vdd_lt_prot_rearm (vdd_lt_prot_rearm),
    .vdd_lt_unlatch    (vdd_lt_unlatch),
    .vdd_ge_brownin    (vdd_ge_brownin),
    .line_ge_brownin   (line_ge_brownin),
    .sw_en             (sw_en),
    .chg_en            (chg_en),
    .sink_en           (sink_en),
    .fault_code        (fault_code)
);

// File: tb/supply_fault_supervisor_tb_top.sv
module supply_fault_supervisor_tb_top;
    localparam int OVP_L   = 8;
    localparam int TCRIT_L = 6;
    localparam int TWARN_L = 40;
    localparam int OLP_L   = 30;
    localparam int SSCP_L  = 11;
    localparam int BROWN_L = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_ge_on, vdd_lt_uvlo, vdd_lt_restart, vdd_lt_prot_off;
    logic vdd_lt_prot_rearm, vdd_lt_unlatch, vdd_ge_brownin, vdd_gt_ovp;
    logic fb_gt_olp = 1'b0, temp_lt_warn = 1'b0, temp_lt_crit = 1'b0;
    logic line_lt_brownout = 1'b0, line_ge_brownin = 1'b1, sense_low = 1'b0;
    logic sw_en, chg_en, sink_en;
    logic [2:0] fault_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    supply_fault_supervisor #(
        .OVP_CYC(OVP_L), .TCRIT_CYC(TCRIT_L), .TWARN_CYC(TWARN_L),
        .OLP_CYC(OLP_L), .SSCP_CYC(SSCP_L), .BROWN_CYC(BROWN_L)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .vdd_ge_on(vdd_ge_on), .vdd_lt_uvlo(vdd_lt_uvlo), .vdd_lt_restart(vdd_lt_restart),
        .vdd_lt_prot_off(vdd_lt_prot_off), .vdd_lt_prot_rearm(vdd_lt_prot_rearm),
        .vdd_lt_unlatch(vdd_lt_unlatch), .vdd_ge_brownin(vdd_ge_brownin),
        .vdd_gt_ovp(vdd_gt_ovp), .fb_gt_olp(fb_gt_olp), .temp_lt_warn(temp_lt_warn),
        .temp_lt_crit(temp_lt_crit), .line_lt_brownout(line_lt_brownout),
        .line_ge_brownin(line_ge_brownin), .sense_low(sense_low),
        .sw_en(sw_en), .chg_en(chg_en), .sink_en(sink_en), .fault_code(fault_code)
    );

    // Supply level in millivolts turned into the comparator flags.
    task automatic drive_vdd(input int mv);
        vdd_ge_on         = (mv >= 17000);
        vdd_lt_uvlo       = (mv < 6500);
        vdd_lt_restart    = (mv < 4700);
        vdd_lt_prot_off   = (mv < 11000);
        vdd_lt_prot_rearm = (mv < 7000);
        vdd_lt_unlatch    = (mv < 4000);
        vdd_ge_brownin    = (mv >= 9500);
        vdd_gt_ovp        = (mv > 24500);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit exp_trip(input int held, input int need);
        return held >= need;
    endfunction

    // From RUN after an auto fault: drain, recharge and start again.
    task automatic recover_auto();
        drive_vdd(10000); step(1);
        check("R5 sink on below 11V", int'(sink_en), 1);
        drive_vdd(6800);  step(1);
        check("R5 charger after 7V", int'(chg_en), 1);
        check("R5 sink off after 7V", int'(sink_en), 0);
        drive_vdd(17500); step(1);
        check("R5 restart", int'(sw_en), 1);
        drive_vdd(15000);
    endtask

    initial begin
        drive_vdd(15000);
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 charger at reset", int'(chg_en), 1);
        check("R1 switch at reset", int'(sw_en), 0);
        check("R1 sink at reset", int'(sink_en), 0);
        check("R1 code at reset", int'(fault_code), 0);

        // R2 startup gating
        step(2);
        check("R2 no start below 17V", int'(sw_en), 0);
        line_ge_brownin = 1'b0;
        drive_vdd(17500); step(2);
        check("R2 no start without line", int'(sw_en), 0);
        line_ge_brownin = 1'b1; step(1);
        check("R2 start", int'(sw_en), 1);
        check("R2 charger off", int'(chg_en), 0);
        drive_vdd(15000);

        // R3 normal undervoltage
        drive_vdd(9000); step(2);
        check("R3 runs at 9V", int'(sw_en), 1);
        drive_vdd(6000); step(1);
        check("R3 stop below 6.5V", int'(sw_en), 0);
        check("R3 charger still off", int'(chg_en), 0);
        drive_vdd(4500); step(1);
        check("R3 charger below 4.7V", int'(chg_en), 1);
        drive_vdd(17500); step(1);
        drive_vdd(15000);
        check("R2 restart", int'(sw_en), 1);

        // R9 brownout
        line_lt_brownout = 1'b1; line_ge_brownin = 1'b0;
        step(BROWN_L);
        check("R9 still on at count", int'(sw_en), 1);
        step(1);
        check("R9 brownout off", int'(sw_en), 0);
        check("R9 brownout code", int'(fault_code), 6);
        drive_vdd(9000);
        line_lt_brownout = 1'b0; line_ge_brownin = 1'b1; step(2);
        check("R9 no brown-in without headroom", int'(sw_en), 0);
        drive_vdd(15000); step(1);
        check("R9 brown-in", int'(sw_en), 1);
        check("R9 code cleared", int'(fault_code), 0);

        // R4 debounce restart, then R5 trip
        fb_gt_olp = 1'b1; step(OLP_L - 1);
        fb_gt_olp = 1'b0; step(1);
        fb_gt_olp = 1'b1; step(OLP_L - 1);
        fb_gt_olp = 1'b0; step(2);
        check("R4 short pulses ignored", int'(sw_en), 1);
        fb_gt_olp = 1'b1; step(OLP_L);
        check("R4 on at count", int'(sw_en), 1);
        step(1);
        fb_gt_olp = 1'b0;
        check("R4 off one later", int'(sw_en), 0);
        check("R5 open-loop code", int'(fault_code), 4);
        drive_vdd(12000); step(2);
        check("R5 no sink above 11V", int'(sink_en), 0);
        recover_auto();

        // R6 raised turn-off level
        drive_vdd(10000); step(1);
        check("R6 stop below 11V", int'(sw_en), 0);
        check("R6 sink instead of wait", int'(sink_en), 1);
        drive_vdd(6800); step(1);
        drive_vdd(17500); step(1);
        drive_vdd(15000);
        check("R6 restart", int'(sw_en), 1);

        // R4/R5 random pulse lengths on open-loop and sense-short
        void'($urandom(32'd4242));
        for (int t = 0; t < 14; t++) begin
            bit sel = 1'($urandom_range(0, 1));
            int need = sel ? SSCP_L : OLP_L;
            int held = int'($urandom_range(1, 2 * need));
            if (sel) sense_low = 1'b1; else fb_gt_olp = 1'b1;
            step(held);
            sense_low = 1'b0; fb_gt_olp = 1'b0;
            step(1);
            check("R4 random debounce", int'(sw_en), int'(!exp_trip(held, need)));
            if (exp_trip(held, need)) begin
                check("R5 random code", int'(fault_code), sel ? 5 : 4);
                recover_auto();
            end
            step(1);
        end

        // R10 simultaneous faults, then R7 and R8
        fb_gt_olp = 1'b1; step(OLP_L - OVP_L);
        drive_vdd(25000); step(OVP_L);
        check("R10 on before both qualify", int'(sw_en), 1);
        step(1);
        fb_gt_olp = 1'b0;
        check("R10 latched code wins", int'(fault_code), 1);
        check("R7 latched off", int'(sw_en), 0);
        drive_vdd(17500); step(3);
        check("R7 17V ignored", int'(sw_en), 0);
        check("R7 charger off high", int'(chg_en), 0);
        drive_vdd(6800); step(1);
        check("R7 charger below 7V", int'(chg_en), 1);
        drive_vdd(9000); step(2);
        check("R7 charger holds below 11V", int'(chg_en), 1);
        drive_vdd(12000); step(1);
        check("R7 charger off at 11V", int'(chg_en), 0);
        drive_vdd(5000); step(2);
        check("R8 no release above 4V", int'(fault_code), 1);
        drive_vdd(3500); step(1);
        check("R8 release code", int'(fault_code), 0);
        check("R8 back to charging", int'(chg_en), 1);

        // R12 latch while charging, R10 ordering of temperature faults
        drive_vdd(15000); step(1);
        temp_lt_crit = 1'b1; temp_lt_warn = 1'b1; step(TCRIT_L + 1);
        check("R12 latch from charging", int'(fault_code), 2);
        check("R12 charger off", int'(chg_en), 0);
        temp_lt_crit = 1'b0; temp_lt_warn = 1'b0;
        drive_vdd(3500); step(1);
        check("R8 release again", int'(fault_code), 0);

        // R7 warm temperature code
        drive_vdd(17500); step(1);
        drive_vdd(15000);
        check("R2 start after release", int'(sw_en), 1);
        temp_lt_warn = 1'b1; step(TWARN_L + 1);
        temp_lt_warn = 1'b0;
        check("R7 warm code", int'(fault_code), 3);
        check("R7 warm off", int'(sw_en), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule